// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block produces one system reset output from three causes: the power-on event, a supply that falls below its trip level, and a watchdog that was not serviced in time. The supply level arrives as a single digitized "supply good" bit from an external comparator. The watchdog is serviced by pulling the chip-select line of the serial memory bus from high to low. Because of this, a host that stops talking to the bus leaves the line static at either level, and the watchdog then expires.

Whenever any cause is present, reset is held. It is released only after a fixed, parameterized number of clock cycles has passed with no cause present. The power-on hold, the hold after a brownout and the pulse after a watchdog expiry all share this stretch length. Two persistent select bits from a status register choose one of three watchdog periods or switch the watchdog off. A parameter selects whether the output is active low or active high.

Top module: `sup_reset_gen`

## Requirements
- R1: With `supply_good` high when `por_n` is released, the reset output stays active through clock edge HOLD_CYCLES+1 after the release. It goes inactive at edge HOLD_CYCLES+2, which includes two cycles of input synchronization.
- R2: When `supply_good` falls, reset becomes active at the third clock edge after the change and stays active while the supply is low. Each supply recovery, including one after a single-cycle dropout during a hold, restarts the full HOLD_CYCLES count. Reset is released at edge HOLD_CYCLES+2 after the last rise.
- R3: With the watchdog enabled and `cs_wdi` held static, either high or low, reset becomes active exactly L clock edges after the previous release. L is the selected period.
- R4: A high-to-low transition of `cs_wdi` restarts the watchdog count at the third clock edge after the transition, so expiry then occurs L edges after that clearing edge. A low-to-high transition does not restart the count. Falling edges spaced closer than L keep reset inactive indefinitely.
- R5: `wd_sel` = 2'b00 selects WD_CYC0 cycles, 2'b01 selects WD_CYC1 and 2'b10 selects WD_CYC2.
- R6: `wd_sel` = 2'b11 disables the watchdog: no activity or inactivity on `cs_wdi` causes reset.
- R7: A watchdog expiry holds reset active for exactly HOLD_CYCLES edges. After release, the watchdog counts a fresh full period from zero.
- R8: With ACTIVE_LOW = 1 the output is 0 when reset is active. With ACTIVE_LOW = 0 it is 1 when reset is active.
- R9: While `por_n` is low, the reset output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on clear from the analog domain, active low |
| supply_good | input | 1 | Comparator result: 1 when the supply is above the trip level |
| cs_wdi | input | 1 | Chip-select line; a falling edge services the watchdog |
| wd_sel | input | 2 | Watchdog period select (00, 01, 10 periods; 11 off) |
| sys_rst | output | 1 | System reset, polarity set by ACTIVE_LOW |

## Verification
The hardest case to reach from the ports is a supply dropout that lasts only one synchronized cycle in the middle of a hold. It must restart the hold rather than be absorbed by it, and that is visible only as a release that comes later by a precise number of cycles. The stimulus releases the supply, then drops it for exactly one cycle ten edges into the hold. The bench then checks that reset is still active on the edge just before the predicted late release and inactive on that edge. A second hard case is a rising edge of the chip-select line in the middle of a watchdog period. The stimulus places a falling edge and a later rising edge on the line, and the bench checks that expiry still lands exactly one period after the falling edge.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Watchdog select encoding (two persistent status bits)
    typedef enum logic [1:0] {
        WD_SHORT = 2'b00,
        WD_MID   = 2'b01,
        WD_LONG  = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
    parameter int HOLD_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic wd_expire,
    output logic active
);

    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HOLD_CYCLES);

    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
        logic              act;
    } st_t;

    st_t  st_d, st_q;
    logic trig;

    always_comb begin
        trig = !supply_ok || wd_expire;
        st_d = st_q;
        if (trig) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != HOLD_MAX) begin
            st_d.cnt = st_q.cnt + HOLD_W'(1);
        end
        st_d.act = trig || (st_d.cnt != HOLD_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.act <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.act;

    // Any cause seen at an edge leaves reset active afterwards
    assert_cause_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> st_q.act);

    // Release only follows a cycle with no cause present
    assert_clean_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.act) |-> $past(supply_ok && !wd_expire));

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
    import sup_pkg::*;
#(
    parameter int WD_CYC0 = 60,
    parameter int WD_CYC1 = 120,
    parameter int WD_CYC2 = 250
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cs_lvl,
    input  wd_sel_e sel,
    input  logic    hold_act,
    output logic    expire
);

    localparam int WD_W = $clog2(max3(WD_CYC0, WD_CYC1, WD_CYC2) + 1);

    typedef struct packed {
        logic [WD_W-1:0] cnt;
        logic            cs_prev;
    } st_t;

    st_t             st_d, st_q;
    logic [WD_W-1:0] limit;
    logic            enabled;
    logic            kick;

    always_comb begin
        enabled = 1'b1;
        unique case (sel)
            WD_SHORT: limit = WD_W'(WD_CYC0);
            WD_MID:   limit = WD_W'(WD_CYC1);
            WD_LONG:  limit = WD_W'(WD_CYC2);
            default: begin
                limit   = WD_W'(WD_CYC2);
                enabled = 1'b0;
            end
        endcase
        kick   = st_q.cs_prev && !cs_lvl;
        expire = enabled && !hold_act && !kick && (st_q.cnt >= limit - WD_W'(1));

        st_d         = st_q;
        st_d.cs_prev = cs_lvl;
        if (!enabled || hold_act || kick) begin
            st_d.cnt = '0;
        end else if (!expire) begin
            st_d.cnt = st_q.cnt + WD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (st_q.cnt == '0));

    assert_off_is_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == WD_OFF) |-> !expire);

    assert_idle_during_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |=> (st_q.cnt == '0));

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
    import sup_pkg::*;
#(
    parameter int HOLD_CYCLES = 20000000,
    parameter int WD_CYC0     = 15000000,
    parameter int WD_CYC1     = 60000000,
    parameter int WD_CYC2     = 140000000,
    parameter int SYNC_STAGES = 2,
    parameter bit ACTIVE_LOW  = 1'b1
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       supply_good,
    input  logic       cs_wdi,
    input  logic [1:0] wd_sel,
    output logic       sys_rst
);

    localparam logic ACT_LEVEL = ACTIVE_LOW ? 1'b0 : 1'b1;

    logic [1:0] sync_q;
    logic       supply_s;
    logic       cs_s;
    logic       wd_expire;
    logic       hold_act;

    sup_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b10)
    ) u_sync (
        .clk  (clk),
        .rst_n(por_n),
        .d    ({cs_wdi, supply_good}),
        .q    (sync_q)
    );

    assign supply_s = sync_q[0];
    assign cs_s     = sync_q[1];

    sup_wdog #(
        .WD_CYC0(WD_CYC0),
        .WD_CYC1(WD_CYC1),
        .WD_CYC2(WD_CYC2)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (por_n),
        .cs_lvl  (cs_s),
        .sel     (wd_sel_e'(wd_sel)),
        .hold_act(hold_act),
        .expire  (wd_expire)
    );

    sup_stretch #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_stretch (
        .clk      (clk),
        .rst_n    (por_n),
        .supply_ok(supply_s),
        .wd_expire(wd_expire),
        .active   (hold_act)
    );

    generate
        if (ACTIVE_LOW) begin : g_low
            assign sys_rst = ~hold_act;
        end else begin : g_high
            assign sys_rst = hold_act;
        end
    endgenerate

    assert_supply_loss_R2: assert property (@(posedge clk) disable iff (!por_n)
        !supply_s |=> (sys_rst == ACT_LEVEL));

    assert_expiry_resets_R3: assert property (@(posedge clk) disable iff (!por_n)
        wd_expire |=> (sys_rst == ACT_LEVEL));

endmodule

// File: tb/tb_sup_reset_gen.sv
module tb_sup_reset_gen;

    localparam int HOLD = 40;
    localparam int W0   = 60;
    localparam int W1   = 120;
    localparam int W2   = 250;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       supply_good = 1'b0;
    logic       cs_wdi = 1'b1;
    logic [1:0] wd_sel = 2'b00;
    logic       rst_l;
    logic       rst_h;
    int         checks = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    sup_reset_gen #(.HOLD_CYCLES(HOLD), .WD_CYC0(W0), .WD_CYC1(W1), .WD_CYC2(W2),
                    .ACTIVE_LOW(1'b1)) dut (
        .clk(clk), .por_n(por_n), .supply_good(supply_good), .cs_wdi(cs_wdi),
        .wd_sel(wd_sel), .sys_rst(rst_l));

    sup_reset_gen #(.HOLD_CYCLES(HOLD), .WD_CYC0(W0), .WD_CYC1(W1), .WD_CYC2(W2),
                    .ACTIVE_LOW(1'b0)) dut_hi (
        .clk(clk), .por_n(por_n), .supply_good(supply_good), .cs_wdi(cs_wdi),
        .wd_sel(wd_sel), .sys_rst(rst_h));

    task automatic chk(input string tag, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, actual, expected, $time);
        end
    endtask

    // advance n rising edges, then land on the following falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic active();
        return ~rst_l;
    endfunction

    // Power-on with a given select and chip-select level; returns at the release edge
    task automatic power_up(input logic [1:0] sel, input logic cs);
        por_n       = 1'b0;
        supply_good = 1'b1;
        cs_wdi      = cs;
        wd_sel      = sel;
        tick(3);
        chk("R9 active while por_n low", active(), 1'b1);
        por_n = 1'b1;
        tick(HOLD + 1);
        chk("R1 still held before release", active(), 1'b1);
        tick(1);
        chk("R1 released at HOLD+2", active(), 1'b0);
    endtask

    task automatic t_polarity();
        por_n = 1'b0;
        tick(2);
        chk("R8 active-high output in reset", rst_h, 1'b1);
        chk("R8 active-low output in reset", rst_l, 1'b0);
        power_up(2'b11, 1'b1);
        chk("R8 active-high output released", rst_h, 1'b0);
        chk("R8 active-low output released", rst_l, 1'b1);
    endtask

    task automatic t_static_high();
        power_up(2'b00, 1'b1);
        tick(W0 - 1);
        chk("R3 static high no expiry yet", active(), 1'b0);
        tick(1);
        chk("R3 static high expiry", active(), 1'b1);
        tick(HOLD - 1);
        chk("R7 watchdog pulse still held", active(), 1'b1);
        tick(1);
        chk("R7 watchdog pulse ends", active(), 1'b0);
        tick(W0 - 1);
        chk("R7 fresh period no expiry yet", active(), 1'b0);
        tick(1);
        chk("R7 fresh period expiry", active(), 1'b1);
    endtask

    task automatic t_static_low();
        power_up(2'b00, 1'b0);
        tick(W0 - 1);
        chk("R3 static low no expiry yet", active(), 1'b0);
        tick(1);
        chk("R3 static low expiry", active(), 1'b1);
    endtask

    task automatic t_periods();
        power_up(2'b01, 1'b1);
        tick(W1 - 1);
        chk("R5 sel01 before expiry", active(), 1'b0);
        tick(1);
        chk("R5 sel01 expiry", active(), 1'b1);
        power_up(2'b10, 1'b1);
        tick(W2 - 1);
        chk("R5 sel10 before expiry", active(), 1'b0);
        tick(1);
        chk("R5 sel10 expiry", active(), 1'b1);
    endtask

    task automatic t_disabled();
        logic seen;
        seen = 1'b0;
        power_up(2'b11, 1'b1);
        for (int i = 0; i < 2 * W2; i++) begin
            tick(1);
            seen |= active();
        end
        cs_wdi = 1'b0;
        for (int i = 0; i < 2 * W2; i++) begin
            tick(1);
            seen |= active();
        end
        chk("R6 disabled watchdog never resets", seen, 1'b0);
    endtask

    task automatic t_kick_edges();
        power_up(2'b00, 1'b1);
        tick(W0 - 10);
        cs_wdi = 1'b0;          // falling edge after edge X
        tick(W0 - 20);
        cs_wdi = 1'b1;          // rising edge at X+W0-20 must not clear
        tick(22);
        chk("R4 no expiry before fall+3+L", active(), 1'b0);
        tick(1);
        chk("R4 expiry at fall+3+L despite rising edge", active(), 1'b1);
    endtask

    task automatic t_kick_train();
        logic seen;
        seen = 1'b0;
        power_up(2'b00, 1'b1);
        for (int i = 0; i < 1200; i++) begin
            cs_wdi = ((i / 20) % 2 == 0) ? 1'b0 : 1'b1;
            tick(1);
            seen |= active();
        end
        chk("R4 regular kicks keep reset off", seen, 1'b0);
    endtask

    task automatic t_brownout();
        power_up(2'b11, 1'b1);
        tick(10);
        supply_good = 1'b0;
        tick(2);
        chk("R2 not yet asserted at edge 2", active(), 1'b0);
        tick(1);
        chk("R2 asserted at edge 3", active(), 1'b1);
        tick(10);
        chk("R2 held while supply low", active(), 1'b1);
        supply_good = 1'b1;     // recovery after edge Z
        tick(10);
        supply_good = 1'b0;     // one-cycle dropout mid-hold
        tick(1);
        supply_good = 1'b1;
        tick(HOLD + 1);
        chk("R2 hold restarted by dropout", active(), 1'b1);
        tick(1);
        chk("R2 release after restarted hold", active(), 1'b0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog timeout of the bench expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        tick(2);
        t_polarity();
        t_static_high();
        t_static_low();
        t_periods();
        t_disabled();
        t_kick_edges();
        t_kick_train();
        t_brownout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule